// File: doc/BRIEF.md
# Distributed Priority Round-Robin Bus Grant Arbiter

This block is one node of a group of up to eight identical arbiters that share the grant decision for one bus. Each node serves eight local device ports. A device posts a request by strobing its push line with a priority level. The node keeps a pending count for every device and level. It broadcasts a 3-bit code for the best level it has pending, and it receives the codes of the other seven nodes.

Every node evaluates the same rules on the same broadcast codes, so all nodes agree on which node wins a cycle without any central controller. Each node numbers the group relative to itself, with itself as index 0. It keeps its own copy of a per-level arbiter precedence pointer in that relative numbering. When the local node wins, it chooses one of its devices with a per-level device precedence pointer. It then drives that device's grant line together with a high-priority flag and a long-packet flag.

A shared busy input covers multi-cycle packets. Two masking rules apply after two-cycle packets. At power-up, reset is held together with the stop input for at least 10 cycles. Reset is then released while stop stays high, so requests are accepted but none are granted. Grants begin once stop drops.

Top module: `dist_grant_arbiter`

## Requirements
- R1: While `rst` is high (sampled at a rising edge), all pending counts and pointers are cleared. From the next cycle on, `grant_o`, `hi_pri_o`, `long_o`, `busy_o` and `bcast_code_o` read 0 until a grant or push occurs after reset.
- R2: Push and broadcast code.
  - A push on device d with level L (0..N_PRI-1) raises that device's count for L by one. A push with a level of N_PRI or above is ignored, and so is a push while that count already equals DEPTH.
  - `bcast_code_o` shows 0 for nothing pending, or L+1 for the highest level L pending on any device. It reflects the counts one cycle after they change, so it updates two cycles after the push strobe.
- R3: The effective code of a node is its broadcast code, with codes above N_PRI treated as 0. In a decision cycle the highest nonzero effective code wins; its level is the code minus 1. The local node grants only when it wins, `stop_i` is low and `busy_i` is low. The grant outputs change at the following clock edge and hold for one cycle.
- R4: Ties between nodes are broken round-robin in relative index order, starting at the winning level's arbiter pointer. After any grant at level L (local or remote), that pointer moves to the winner's relative index plus 1, modulo N_ARB.
- R5: A local win grants the device with a nonzero count at the winning level, chosen round-robin from that level's device pointer. The pointer then moves to that device plus 1, modulo N_DEV, and the device's count drops by one. A push and a grant on the same count in one cycle net to no change.
- R6: `grant_o` is one-hot or zero. `hi_pri_o` is high with a grant at level HI_MIN (3) or above. `long_o` is high with a grant whose level bit is set in LONG_LEVELS (default levels 2 and 3): these packets last LONG_LEN (5) cycles, and all others last 2.
- R7: While `stop_i` is high no grant is made, but pushes are still counted and the broadcast code still updates.
- R8: `busy_o` is high for the packet length minus one cycle after each local grant, starting in the cycle the grant is shown: 1 cycle for a short packet, 4 for a long one. No grant is made in a cycle where `busy_i` is high.
- R9: After a short-packet grant decided in cycle t by relative node w, in cycle t+2 node w's effective code is 0 at every node. When w is the local node, `bcast_code_o` reads 0 in cycle t+2.
- R10: After a short-packet grant at level 0 or 1 decided in cycle t, in cycle t+2 every effective code above HI_MIN (levels 3 and up) is treated as 0.
- R11: `peer_code_i` bits [3k+2:3k] carry the code of relative node k+1 for k = 0..N_ARB-2, and the local node is relative index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | System-wide stop; blocks grants, not requests |
| busy_i | input | 1 | Shared busy of all nodes; a packet is in flight |
| dev_push_i | input | N_DEV | Request strobe per local device |
| dev_lvl_i | input | 3*N_DEV | Request level per device, device d at bits [3d+2:3d] |
| peer_code_i | input | 3*(N_ARB-1) | Broadcast codes of the other nodes, relative order |
| bcast_code_o | output | 3 | This node's broadcast code (0 = none, L+1 = level L) |
| grant_o | output | N_DEV | One-hot device grant |
| hi_pri_o | output | 1 | Granted level is HI_MIN or above |
| long_o | output | 1 | Granted packet is long |
| busy_o | output | 1 | This node's contribution to the shared busy |

## Verification
The bench drives runs with the peer codes all silent, which isolates device round-robin and queue drain. It also drives runs with all peers fixed at the top code, where every cycle is a tie and the node-pointer rotation alone decides who wins. Random peer codes, including invalid values above N_PRI, mix node wins, remote wins and the two-cycle masking windows, and tell apart a correct hazard timing from one shifted by a cycle. Pushes at full depth and at invalid levels during stop confirm counts saturate, while a stop phase with pending work separates request acceptance from grant issue.

// File: rtl/dga_pkg.sv
package dga_pkg;
  // width of a broadcast code / priority level
  localparam int LVL_W     = 3;
  // node index field width in the hazard record (up to 8 nodes)
  localparam int NODE_W    = 3;
  // cycles of a short packet; the hazard window is placed for this length
  localparam int SHORT_LEN = 2;

  // record of a short-packet grant, carried through two pipeline stages
  typedef struct packed {
    logic              vld;
    logic [NODE_W-1:0] win;
    logic [LVL_W-1:0]  lvl;
  } hz_stage_t;
endpackage

// File: rtl/dga_rr_pick.sv
// Round-robin first-set search starting at a pointer.
module dga_rr_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found = 1'b1;
        idx   = W'((int'(ptr) + k) % N);
      end
    end
  end
endmodule

// File: rtl/dga_req_store.sv
// Per-device, per-level pending counters and the registered broadcast code.
module dga_req_store import dga_pkg::*; #(
  parameter int N_DEV = 8,
  parameter int N_PRI = 6,
  parameter int DEPTH = 6,
  localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DEV-1:0]       push,
  input  logic [N_DEV*LVL_W-1:0] push_lvl,
  input  logic                   pop,
  input  logic [DEV_W-1:0]       pop_dev,
  input  logic [LVL_W-1:0]       pop_lvl,
  input  logic                   suppress,
  output logic [N_DEV*N_PRI-1:0] pend,
  output logic [LVL_W-1:0]       code_o
);
  logic [N_PRI-1:0] lvl_any;
  logic [LVL_W-1:0] code_nx;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    for (genvar l = 0; l < N_PRI; l++) begin : g_lvl
      logic [CNT_W-1:0] cnt_q;
      logic             inc, dec;
      assign inc = push[d] && (push_lvl[d*LVL_W +: LVL_W] == LVL_W'(l)) &&
                   (cnt_q < CNT_W'(DEPTH));
      assign dec = pop && (pop_dev == DEV_W'(d)) && (pop_lvl == LVL_W'(l));
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec);
      end
      assign pend[d*N_PRI + l] = (cnt_q != '0);

      // R2: a count never passes the queue depth
      a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));
    end
  end

  always_comb begin
    for (int l = 0; l < N_PRI; l++) begin
      lvl_any[l] = 1'b0;
      for (int d = 0; d < N_DEV; d++) lvl_any[l] = lvl_any[l] | pend[d*N_PRI + l];
    end
    code_nx = '0;
    for (int l = 0; l < N_PRI; l++)
      if (lvl_any[l]) code_nx = LVL_W'(l + 1);
  end

  always_ff @(posedge clk) begin
    if (rst)           code_o <= '0;
    else if (suppress) code_o <= '0;
    else               code_o <= code_nx;
  end

  // R2: the broadcast code stays within the level range
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    code_o <= LVL_W'(N_PRI));
endmodule

// File: rtl/dga_hazard_track.sv
// Tracks short-packet grants for the masking window and the local busy span.
module dga_hazard_track import dga_pkg::*; #(
  parameter int LONG_LEN = 5,
  localparam int BW = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             local_go,
  input  logic [NODE_W-1:0] win,
  input  logic [LVL_W-1:0] lvl,
  input  logic             is_long,
  output hz_stage_t        st2,
  output logic             self_supp,
  output logic             busy_o
);
  hz_stage_t      st1;
  logic [BW-1:0]  bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1  <= '0;
      st2  <= '0;
      bcnt <= '0;
    end else begin
      st2     <= st1;
      st1.vld <= go && !is_long;
      st1.win <= win;
      st1.lvl <= lvl;
      if (local_go)
        bcnt <= is_long ? BW'(LONG_LEN - 1) : BW'(SHORT_LEN - 1);
      else if (bcnt != '0)
        bcnt <= bcnt - 1'b1;
    end
  end

  assign self_supp = st1.vld && (st1.win == '0);
  assign busy_o    = (bcnt != '0);

  // R9: a masking record always comes from the preceding stage
  a_r9_stage_order: assert property (@(posedge clk) disable iff (rst)
    st1.vld |=> st2.vld);
endmodule

// File: rtl/dist_grant_arbiter.sv
module dist_grant_arbiter import dga_pkg::*; #(
  parameter int             N_ARB       = 8,
  parameter int             N_DEV       = 8,
  parameter int             N_PRI       = 6,
  parameter int             DEPTH       = 6,
  parameter int             LONG_LEN    = 5,
  parameter int             HI_MIN      = 3,
  parameter int             CAP_LVL_MAX = 1,
  parameter logic [N_PRI-1:0] LONG_LEVELS = 6'b001100
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stop_i,
  input  logic                         busy_i,
  input  logic [N_DEV-1:0]             dev_push_i,
  input  logic [N_DEV*LVL_W-1:0]       dev_lvl_i,
  input  logic [(N_ARB-1)*LVL_W-1:0]   peer_code_i,
  output logic [LVL_W-1:0]             bcast_code_o,
  output logic [N_DEV-1:0]             grant_o,
  output logic                         hi_pri_o,
  output logic                         long_o,
  output logic                         busy_o
);
  localparam int ARB_W = (N_ARB > 1) ? $clog2(N_ARB) : 1;
  localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  logic [N_DEV*N_PRI-1:0] pend;
  hz_stage_t              st2;
  logic                   self_supp;
  logic [LVL_W-1:0]       raw_code [N_ARB];
  logic [LVL_W-1:0]       eff_code [N_ARB];
  logic [LVL_W-1:0]       top_code, lvl_idx;
  logic [N_ARB-1:0]       arb_req;
  logic [N_DEV-1:0]       dev_req;
  logic [ARB_W-1:0]       arb_ptr [N_PRI];
  logic [DEV_W-1:0]       dev_ptr [N_PRI];
  logic [ARB_W-1:0]       arb_win;
  logic [DEV_W-1:0]       dev_win;
  logic                   arb_found, dev_found, go, local_go, is_long;

  // R11: relative numbering, local node is index 0
  for (genvar j = 0; j < N_ARB; j++) begin : g_raw
    if (j == 0) begin : g_self
      assign raw_code[j] = bcast_code_o;
    end else begin : g_peer
      assign raw_code[j] = peer_code_i[(j-1)*LVL_W +: LVL_W];
    end
  end

  // R3 R9 R10: effective codes after range check and hazard masking
  always_comb begin
    for (int j = 0; j < N_ARB; j++) begin
      eff_code[j] = raw_code[j];
      if (raw_code[j] > LVL_W'(N_PRI)) eff_code[j] = '0;
      if (st2.vld && (int'(st2.win) == j)) eff_code[j] = '0;
      if (st2.vld && (st2.lvl <= LVL_W'(CAP_LVL_MAX)) &&
          (raw_code[j] > LVL_W'(HI_MIN)))
        eff_code[j] = '0;
    end
    top_code = '0;
    for (int j = 0; j < N_ARB; j++)
      if (eff_code[j] > top_code) top_code = eff_code[j];
    for (int j = 0; j < N_ARB; j++)
      arb_req[j] = (top_code != '0) && (eff_code[j] == top_code);
    lvl_idx = (top_code == '0) ? '0 : top_code - 1'b1;
    for (int d = 0; d < N_DEV; d++)
      dev_req[d] = pend[d*N_PRI + int'(lvl_idx)];
  end

  dga_rr_pick #(.N(N_ARB)) u_arb_pick (
    .req(arb_req), .ptr(arb_ptr[lvl_idx]), .found(arb_found), .idx(arb_win));

  dga_rr_pick #(.N(N_DEV)) u_dev_pick (
    .req(dev_req), .ptr(dev_ptr[lvl_idx]), .found(dev_found), .idx(dev_win));

  assign is_long  = LONG_LEVELS[lvl_idx];
  assign go       = (top_code != '0) && !stop_i && !busy_i && arb_found &&
                    ((arb_win != '0) || dev_found);
  assign local_go = go && (arb_win == '0);

  dga_req_store #(.N_DEV(N_DEV), .N_PRI(N_PRI), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(dev_push_i), .push_lvl(dev_lvl_i),
    .pop(local_go), .pop_dev(dev_win), .pop_lvl(lvl_idx),
    .suppress(self_supp), .pend(pend), .code_o(bcast_code_o));

  dga_hazard_track #(.LONG_LEN(LONG_LEN)) u_hazard (
    .clk(clk), .rst(rst), .go(go), .local_go(local_go),
    .win(NODE_W'(arb_win)), .lvl(lvl_idx), .is_long(is_long),
    .st2(st2), .self_supp(self_supp), .busy_o(busy_o));

  // R4 R5: per-level precedence pointers
  for (genvar l = 0; l < N_PRI; l++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        arb_ptr[l] <= '0;
        dev_ptr[l] <= '0;
      end else begin
        if (go && (lvl_idx == LVL_W'(l)))
          arb_ptr[l] <= ARB_W'((int'(arb_win) + 1) % N_ARB);
        if (local_go && (lvl_idx == LVL_W'(l)))
          dev_ptr[l] <= DEV_W'((int'(dev_win) + 1) % N_DEV);
      end
    end
  end

  // R6: registered grant outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o  <= '0;
      hi_pri_o <= 1'b0;
      long_o   <= 1'b0;
    end else begin
      grant_o  <= local_go ? (N_DEV'(1) << dev_win) : '0;
      hi_pri_o <= local_go && (lvl_idx >= LVL_W'(HI_MIN));
      long_o   <= local_go && is_long;
    end
  end

  // R6: at most one device granted
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  // R6: flags only accompany a grant
  a_r6_flags_with_grant: assert property (@(posedge clk) disable iff (rst)
    (hi_pri_o || long_o) |-> (grant_o != '0));
  // R7: stop blocks the next grant
  a_r7_stop_blocks: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (grant_o == '0));
  // R8: shared busy blocks the next grant
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (grant_o == '0));
  // R8: a long grant raises busy while it is shown
  a_r8_long_busy: assert property (@(posedge clk) disable iff (rst)
    ((grant_o != '0) && long_o) |-> busy_o);
  // R9: after a short local grant the broadcast goes quiet
  a_r9_self_quiet: assert property (@(posedge clk) disable iff (rst)
    ((grant_o != '0) && !long_o) |=> (bcast_code_o == '0));
endmodule

// File: tb/dist_grant_arbiter_test.sv
module dist_grant_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8, ND = 8, NP = 6, DEPTH = 6, LLEN = 5;
  localparam int HI_MIN = 3, CAPMAX = 1;
  localparam logic [NP-1:0] LONG_LEVELS = 6'b001100;

  logic clk = 1'b0;
  logic rst, stop_i, busy_i;
  logic [ND-1:0]       dev_push_i;
  logic [ND*3-1:0]     dev_lvl_i;
  logic [(NA-1)*3-1:0] peer_code_i;
  logic [2:0]          bcast_code_o;
  logic [ND-1:0]       grant_o;
  logic                hi_pri_o, long_o, busy_o;

  dist_grant_arbiter #(.N_ARB(NA), .N_DEV(ND), .N_PRI(NP), .DEPTH(DEPTH),
    .LONG_LEN(LLEN), .HI_MIN(HI_MIN), .CAP_LVL_MAX(CAPMAX),
    .LONG_LEVELS(LONG_LEVELS)) uut (
    .clk(clk), .rst(rst), .stop_i(stop_i), .busy_i(busy_i),
    .dev_push_i(dev_push_i), .dev_lvl_i(dev_lvl_i), .peer_code_i(peer_code_i),
    .bcast_code_o(bcast_code_o), .grant_o(grant_o), .hi_pri_o(hi_pri_o),
    .long_o(long_o), .busy_o(busy_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nerr = 0;
  bit done = 0;

  // reference state built from the requirements
  int m_cnt [ND][NP];
  int m_aptr [NP];
  int m_dptr [NP];
  int m_code, m_gbusy, m_obusy;
  int s1v, s1w, s1l, s2v, s2w, s2l;
  int e_gnt, e_hi, e_long;

  task automatic chk(string tag, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int level_code();
    int c = 0;
    for (int l = 0; l < NP; l++)
      for (int d = 0; d < ND; d++)
        if (m_cnt[d][l] > 0) c = l + 1;
    return c;
  endfunction

  task automatic model_clear();
    for (int d = 0; d < ND; d++)
      for (int l = 0; l < NP; l++) m_cnt[d][l] = 0;
    for (int l = 0; l < NP; l++) begin m_aptr[l] = 0; m_dptr[l] = 0; end
    m_code = 0; m_gbusy = 0; m_obusy = 0;
    s1v = 0; s1w = 0; s1l = 0; s2v = 0; s2w = 0; s2l = 0;
    e_gnt = 0; e_hi = 0; e_long = 0;
  endtask

  // One cycle: check outputs, drive inputs, advance the reference.
  // peer_fix >= 0 forces every peer to that code.
  task automatic step(string tag, bit r, bit s, int push_pct, int peer_pct,
                      int peer_fix);
    int peers [NA];
    int pl [ND];
    bit pv [ND];
    int eff [NA];
    int top, lvl, win, dev, go, loc, lng, newc;
    // outputs registered at the last edge
    chk(tag, "grant R3 R4 R5 R9 R10 R11", int'(grant_o), e_gnt);
    chk(tag, "hi_pri R6", int'(hi_pri_o), e_hi);
    chk(tag, "long R6", int'(long_o), e_long);
    chk(tag, "busy R8", int'(busy_o), (m_obusy > 0) ? 1 : 0);
    chk(tag, "bcast R2", int'(bcast_code_o), m_code);
    // stimulus
    for (int d = 0; d < ND; d++) begin
      pv[d] = ($urandom_range(99) < push_pct);
      pl[d] = ($urandom_range(99) < 6) ? 6 + $urandom_range(1) : $urandom_range(NP-1);
      dev_push_i[d] = pv[d];
      dev_lvl_i[d*3 +: 3] = 3'(pl[d]);
    end
    peers[0] = 0;
    for (int j = 1; j < NA; j++) begin
      if (peer_fix >= 0) peers[j] = peer_fix;
      else if ($urandom_range(99) < peer_pct) peers[j] = $urandom_range(7);
      else peers[j] = 0;
      peer_code_i[(j-1)*3 +: 3] = 3'(peers[j]);
    end
    rst = r; stop_i = s; busy_i = (m_gbusy > 0);
    // reference decision
    go = 0; loc = 0; win = 0; dev = 0; lvl = 0; lng = 0; top = 0;
    for (int j = 0; j < NA; j++) begin
      eff[j] = (j == 0) ? m_code : peers[j];
      if (eff[j] > NP) eff[j] = 0;
      if (s2v != 0 && s2w == j) eff[j] = 0;
      if (s2v != 0 && s2l <= CAPMAX && eff[j] > HI_MIN) eff[j] = 0;
      if (eff[j] > top) top = eff[j];
    end
    if (top > 0 && !s && m_gbusy == 0) begin
      lvl = top - 1;
      for (int k = NA - 1; k >= 0; k--)
        if (eff[(m_aptr[lvl] + k) % NA] == top) win = (m_aptr[lvl] + k) % NA;
      go = 1;
      if (win == 0) begin
        go = 0;
        for (int k = ND - 1; k >= 0; k--)
          if (m_cnt[(m_dptr[lvl] + k) % ND][lvl] > 0) begin
            dev = (m_dptr[lvl] + k) % ND; go = 1;
          end
        loc = go;
      end
      lng = LONG_LEVELS[lvl];
    end
    if (r) begin
      model_clear();
    end else begin
      newc = (s1v != 0 && s1w == 0) ? 0 : level_code();
      s2v = s1v; s2w = s1w; s2l = s1l;
      s1v = (go != 0 && lng == 0) ? 1 : 0; s1w = win; s1l = lvl;
      if (go != 0) m_gbusy = lng ? LLEN - 1 : 1;
      else if (m_gbusy > 0) m_gbusy--;
      if (loc != 0) m_obusy = lng ? LLEN - 1 : 1;
      else if (m_obusy > 0) m_obusy--;
      for (int d = 0; d < ND; d++) begin
        int inc;
        inc = (pv[d] && pl[d] < NP && m_cnt[d][pl[d]] < DEPTH) ? 1 : 0;
        if (pv[d] && pl[d] < NP) m_cnt[d][pl[d]] += inc;
      end
      if (loc != 0) begin
        m_cnt[dev][lvl]--;
        m_dptr[lvl] = (dev + 1) % ND;
      end
      if (go != 0) m_aptr[lvl] = (win + 1) % NA;
      e_gnt  = loc ? (1 << dev) : 0;
      e_hi   = (loc != 0 && lvl >= HI_MIN) ? 1 : 0;
      e_long = (loc != 0 && lng != 0) ? 1 : 0;
      m_code = newc;
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    model_clear();
    rst = 1'b1; stop_i = 1'b1; busy_i = 1'b0;
    dev_push_i = '0; dev_lvl_i = '0; peer_code_i = '0;
    @(negedge clk);
    @(negedge clk);
    // R1: reset with stop held, pushes ignored
    for (int i = 0; i < 10; i++) step("R1", 1, 1, 40, 50, -1);
    // R7: stop held, requests counted, nothing granted; R2 saturation
    for (int i = 0; i < 30; i++) step("R7", 0, 1, 60, 0, -1);
    // R5: silent peers, local queue drains round-robin
    for (int i = 0; i < 150; i++) step("R5", 0, 0, 0, 0, 0);
    // R2: refill past depth under stop, then drain
    for (int i = 0; i < 20; i++) step("R2", 0, 1, 80, 0, -1);
    // R4: every peer ties at the top code
    for (int i = 0; i < 200; i++) step("R4", 0, 0, 20, 0, NP);
    // R9 R10: random peer codes with frequent short packets
    for (int i = 0; i < 3000; i++) step("R9 R10", 0, 0, 25, 40, -1);
    // R3 R11: sparse peers, occasional stop bursts
    for (int i = 0; i < 3000; i++)
      step("R3 R11", 0, ($urandom_range(99) < 8), 15, 15, -1);
    // R8: heavy mixed traffic with many long packets
    for (int i = 0; i < 1500; i++) step("R8", 0, 0, 50, 60, -1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule